// File: doc/BRIEF.md
# Receive Address Filter and Acknowledge Policy

This block follows a bit-level receiver on a single-wire, multi-drop consumer-electronics control bus. The receiver hands it one strobe per assembled byte, a flag marking the final byte of a message, a strobe for each acknowledge slot, and strobes for three waveform faults. The first byte of each message is the header, and its low four bits carry the destination logical address. When the header arrives, the block classifies the message. Its own address gives accepted-and-acknowledged. Address 15 is broadcast. Any other address is monitored when listen mode is on and skipped otherwise. The block then applies that class to every later byte, acknowledge slot and fault until the message ends or is aborted.

All outputs are registered. The single-cycle requests are ack drive, broadcast negative acknowledge, error bit and abort, and each one is due the cycle after the strobe that causes it. The seven sticky status flags are cleared by writing 1 to their bit of `stat_clr`. The byte following reset, a completed message or an abort is always treated as a new header. The FSM states are `ST_IDLE` (waiting for a header), `ST_ACCEPT`, `ST_MONITOR`, `ST_BCAST`, `ST_SKIP` and `ST_TAIL` (final byte taken, waiting for its acknowledge slot). The transitions are:
- header → class state.
- final byte → `ST_TAIL`.
- ack slot in `ST_TAIL` → `ST_IDLE`.
- any abort → `ST_IDLE`.
- final byte in `ST_SKIP` → `ST_IDLE`.

Top module: `rx_accept_policy`

## Requirements
- R1: The header destination is `rx_byte[3:0]`. For an address n below 15 with `own_mask[n]` set, `ack_drive` pulses one cycle after the header strobe and after every later byte of that message.
- R2: If a non-broadcast header does not match and `listen_en` is low, there is no acknowledge and no flag. Later bytes and faults have no effect until a final byte ends the message.
- R3: If a non-matching header arrives with `listen_en` high, the message is monitored. Its bytes set the byte flag, and `ack_drive` stays low.
- R4: Destination 15 is broadcast. It is received whatever the mask and listen settings are, and it is never positively acknowledged.
- R5: A byte that arrives in a receiving state while the byte flag (bit 0) is still set is an overrun. It sets flag bit 2, pulses `rx_abort` and gives no acknowledge. For a broadcast it also pulses `nack_bcast`.
- R6: A short-period fault sets flag bit 4 and always pulses `err_bit_req`. It does not abort.
- R7: A long-period fault sets flag bit 5 and always aborts. It requests an error bit when `pol_long_gen` is set or the message is broadcast.
- R8: A rising-edge fault sets flag bit 3 and aborts only when `pol_rise_stop` is set. It requests an error bit when `pol_rise_gen` is set, or when the message is broadcast with `pol_rise_stop` set and `pol_bc_no_err` clear.
- R9: A negative acknowledge slot (`ack_slot_ok` low) during a broadcast or monitored message sets flag bit 6 and aborts. This also holds for the slot of the final byte. In an accepted message the slot has no effect.
- R10: A final byte that is accepted, monitored or broadcast sets the end flag (bit 1) in the same cycle as the byte flag. Its acknowledge slot then returns the block to waiting for a header.
- R11: Writing 1 to a bit of `stat_clr` clears that flag. If the same flag is set in the same cycle, the set wins.
- R12: After reset, all request outputs and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_mask | input | 15 | Accepted logical addresses, bit n for address n |
| listen_en | input | 1 | Monitor non-matching messages |
| pol_rise_stop | input | 1 | Rising-edge fault aborts reception |
| pol_rise_gen | input | 1 | Rising-edge fault requests an error bit |
| pol_long_gen | input | 1 | Long-period fault requests an error bit |
| pol_bc_no_err | input | 1 | Suppress the broadcast rising-edge error-bit override |
| rx_byte | input | 8 | Received byte |
| rx_byte_stb | input | 1 | Byte complete strobe |
| rx_eom | input | 1 | Byte is the last of its message |
| ack_slot_stb | input | 1 | Acknowledge slot observed |
| ack_slot_ok | input | 1 | Slot judged a positive acknowledge |
| rise_err_stb | input | 1 | Rising-edge fault strobe |
| short_err_stb | input | 1 | Short-period fault strobe |
| long_err_stb | input | 1 | Long-period fault strobe |
| stat_clr | input | 7 | Write-1-to-clear for the flags |
| ack_drive | output | 1 | Drive a positive acknowledge |
| nack_bcast | output | 1 | Drive a negative acknowledge on a broadcast |
| err_bit_req | output | 1 | Request an error bit |
| rx_abort | output | 1 | Reception aborted |
| stat_flags | output | 7 | Sticky flags: 0 byte, 1 end, 2 overrun, 3 rise, 4 short, 5 long, 6 missing ack |

## Verification
Every request pulse and every flag change is registered once, so each is due exactly one cycle after the strobe or clear that causes it. No response is expected in any other cycle. The driver applies one stimulus per cycle on the falling edge and queues the full expected output word for that cycle. The monitor compares it shortly after the following rising edge. Because an item is queued for every cycle, a pulse that comes a cycle early or late, or is missing, shows up as a mismatch.

// File: rtl/rxap_pkg.sv
package rxap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACCEPT  = 3'd1,
        ST_MONITOR = 3'd2,
        ST_BCAST   = 3'd3,
        ST_SKIP    = 3'd4,
        ST_TAIL    = 3'd5
    } rx_state_e;

    typedef enum logic [1:0] {
        K_ACCEPT  = 2'd0,
        K_MONITOR = 2'd1,
        K_BCAST   = 2'd2,
        K_NONE    = 2'd3
    } rx_kind_e;

    localparam int NUM_STAT = 7;
    localparam int SI_BYTE  = 0;
    localparam int SI_END   = 1;
    localparam int SI_OVR   = 2;
    localparam int SI_RISE  = 3;
    localparam int SI_SHORT = 4;
    localparam int SI_LONG  = 5;
    localparam int SI_MACK  = 6;

    typedef struct packed {
        logic rise_stop;
        logic rise_gen;
        logic long_gen;
        logic bc_no_err;
    } err_policy_t;

endpackage

// File: rtl/rxap_addr_match.sv
module rxap_addr_match #(
    parameter int ADDR_W = 4,
    localparam int OWN_W = (1 << ADDR_W) - 1
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [OWN_W-1:0]  own_mask,
    output logic              is_bcast,
    output logic              is_own
);
    logic [OWN_W-1:0] hit;

    for (genvar i = 0; i < OWN_W; i++) begin : g_hit
        assign hit[i] = own_mask[i] && (dest == ADDR_W'(i));
    end

    assign is_bcast = (dest == ADDR_W'(OWN_W));
    assign is_own   = |hit;
endmodule

// File: rtl/rxap_err_policy.sv
module rxap_err_policy
    import rxap_pkg::*;
(
    input  logic        live,
    input  logic        in_bcast,
    input  err_policy_t pol,
    input  logic        rise,
    input  logic        short_p,
    input  logic        long_p,
    output logic        abort_req,
    output logic        errbit_req
);
    logic rise_bit;
    logic long_bit;

    assign rise_bit = pol.rise_gen || (in_bcast && pol.rise_stop && !pol.bc_no_err);
    assign long_bit = pol.long_gen || in_bcast;

    assign abort_req  = live && (long_p || (rise && pol.rise_stop));
    assign errbit_req = live && (short_p || (long_p && long_bit) || (rise && rise_bit));
endmodule

// File: rtl/rxap_status.sv
module rxap_status #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_o[i] <= 1'b0;
            else if (set_i[i])
                flags_o[i] <= 1'b1;
            else if (clr_i[i])
                flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_accept_policy.sv
module rx_accept_policy
    import rxap_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8,
    localparam int OWN_W = (1 << ADDR_W) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OWN_W-1:0]    own_mask,
    input  logic                listen_en,
    input  logic                pol_rise_stop,
    input  logic                pol_rise_gen,
    input  logic                pol_long_gen,
    input  logic                pol_bc_no_err,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                rx_byte_stb,
    input  logic                rx_eom,
    input  logic                ack_slot_stb,
    input  logic                ack_slot_ok,
    input  logic                rise_err_stb,
    input  logic                short_err_stb,
    input  logic                long_err_stb,
    input  logic [NUM_STAT-1:0] stat_clr,
    output logic                ack_drive,
    output logic                nack_bcast,
    output logic                err_bit_req,
    output logic                rx_abort,
    output logic [NUM_STAT-1:0] stat_flags
);
    rx_state_e state_q, nxt_state;
    rx_kind_e  kind_q, nxt_kind, hdr_kind, cur_kind;

    logic hdr_bcast, hdr_own;
    logic fault_live, fault_bcast, pol_abort, pol_err;
    logic ack_d, nack_d, err_d, abort_d;
    logic [NUM_STAT-1:0] set_d;
    logic unused_hi;
    err_policy_t pol;

    assign unused_hi = ^rx_byte[BYTE_W-1:ADDR_W];
    assign pol = '{rise_stop: pol_rise_stop, rise_gen: pol_rise_gen,
                   long_gen: pol_long_gen, bc_no_err: pol_bc_no_err};

    rxap_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .dest     (rx_byte[ADDR_W-1:0]),
        .own_mask (own_mask),
        .is_bcast (hdr_bcast),
        .is_own   (hdr_own)
    );

    always_comb begin
        if (hdr_bcast)      hdr_kind = K_BCAST;
        else if (hdr_own)   hdr_kind = K_ACCEPT;
        else if (listen_en) hdr_kind = K_MONITOR;
        else                hdr_kind = K_NONE;
    end

    assign cur_kind    = (state_q == ST_IDLE) ? hdr_kind : kind_q;
    assign fault_live  = (state_q != ST_SKIP);
    assign fault_bcast = (state_q != ST_IDLE) && (kind_q == K_BCAST);

    rxap_err_policy u_pol (
        .live       (fault_live),
        .in_bcast   (fault_bcast),
        .pol        (pol),
        .rise       (rise_err_stb),
        .short_p    (short_err_stb),
        .long_p     (long_err_stb),
        .abort_req  (pol_abort),
        .errbit_req (pol_err)
    );

    function automatic rx_state_e kind_state(input rx_kind_e k);
        unique case (k)
            K_ACCEPT:  return ST_ACCEPT;
            K_MONITOR: return ST_MONITOR;
            K_BCAST:   return ST_BCAST;
            default:   return ST_SKIP;
        endcase
    endfunction

    // next state and next-cycle requests
    always_comb begin
        nxt_state = state_q;
        nxt_kind  = kind_q;
        ack_d     = 1'b0;
        nack_d    = 1'b0;
        err_d     = 1'b0;
        abort_d   = 1'b0;
        set_d     = '0;

        if (fault_live) begin
            set_d[SI_RISE]  = rise_err_stb;
            set_d[SI_SHORT] = short_err_stb;
            set_d[SI_LONG]  = long_err_stb;
            err_d           = pol_err;
            if (pol_abort) begin
                abort_d   = 1'b1;
                nxt_state = ST_IDLE;
            end
        end

        if (!abort_d) begin
            unique case (state_q)
                ST_IDLE, ST_ACCEPT, ST_MONITOR, ST_BCAST: begin
                    if (rx_byte_stb) begin
                        if (cur_kind == K_NONE) begin
                            nxt_state = rx_eom ? ST_IDLE : ST_SKIP;
                        end else if (stat_flags[SI_BYTE]) begin
                            set_d[SI_OVR] = 1'b1;
                            abort_d       = 1'b1;
                            nack_d        = (cur_kind == K_BCAST);
                            nxt_state     = ST_IDLE;
                        end else begin
                            set_d[SI_BYTE] = 1'b1;
                            set_d[SI_END]  = rx_eom;
                            ack_d          = (cur_kind == K_ACCEPT);
                            nxt_kind       = cur_kind;
                            nxt_state      = rx_eom ? ST_TAIL : kind_state(cur_kind);
                        end
                    end else if (ack_slot_stb && !ack_slot_ok &&
                                 state_q != ST_IDLE && kind_q != K_ACCEPT) begin
                        set_d[SI_MACK] = 1'b1;
                        abort_d        = 1'b1;
                        nxt_state      = ST_IDLE;
                    end
                end
                ST_TAIL: begin
                    if (ack_slot_stb) begin
                        nxt_state = ST_IDLE;
                        if (!ack_slot_ok && kind_q != K_ACCEPT) begin
                            set_d[SI_MACK] = 1'b1;
                            abort_d        = 1'b1;
                        end
                    end
                end
                ST_SKIP: begin
                    if (rx_byte_stb && rx_eom)
                        nxt_state = ST_IDLE;
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_NONE;
        end else begin
            state_q <= nxt_state;
            kind_q  <= nxt_kind;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_drive   <= 1'b0;
            nack_bcast  <= 1'b0;
            err_bit_req <= 1'b0;
            rx_abort    <= 1'b0;
        end else begin
            ack_drive   <= ack_d;
            nack_bcast  <= nack_d;
            err_bit_req <= err_d;
            rx_abort    <= abort_d;
        end
    end

    rxap_status #(.N(NUM_STAT)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_d),
        .clr_i   (stat_clr),
        .flags_o (stat_flags)
    );
endmodule

// File: rtl/rxap_checker.sv
module rxap_checker
    import rxap_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input rx_state_e           state,
    input logic                rx_byte_stb,
    input logic                rise_err_stb,
    input logic                short_err_stb,
    input logic                long_err_stb,
    input logic                ack_drive,
    input logic                nack_bcast,
    input logic                err_bit_req,
    input logic                rx_abort,
    input logic [NUM_STAT-1:0] stat_flags
);
    a_r1_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> $past(rx_byte_stb));

    a_r5_ack_not_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_drive, rx_abort}));

    a_r5_nack_implies_abort: assert property (@(posedge clk) disable iff (!rst_n)
        nack_bcast |-> rx_abort);

    a_r6_short_gives_errbit: assert property (@(posedge clk) disable iff (!rst_n)
        (short_err_stb && state != ST_SKIP) |=> err_bit_req);

    a_r7_long_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (long_err_stb && state != ST_SKIP) |=> rx_abort);

    a_r8_errbit_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        err_bit_req |-> $past(rise_err_stb || short_err_stb || long_err_stb));

    a_r10_end_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_flags[SI_END]) |-> $rose(stat_flags[SI_BYTE]));
endmodule

bind rx_accept_policy rxap_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .rx_byte_stb   (rx_byte_stb),
    .rise_err_stb  (rise_err_stb),
    .short_err_stb (short_err_stb),
    .long_err_stb  (long_err_stb),
    .ack_drive     (ack_drive),
    .nack_bcast    (nack_bcast),
    .err_bit_req   (err_bit_req),
    .rx_abort      (rx_abort),
    .stat_flags    (stat_flags)
);

// File: tb/rx_accept_policy_tb_top.sv
module rx_accept_policy_tb_top;
    localparam logic [6:0] FB = 7'h01, FE = 7'h02, FO = 7'h04, FR = 7'h08,
                           FS = 7'h10, FL = 7'h20, FM = 7'h40, FALL = 7'h7F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [14:0] own_mask = 15'h0021;
    logic listen_en = 1'b0;
    logic pol_rise_stop = 1'b0, pol_rise_gen = 1'b0, pol_long_gen = 1'b0, pol_bc_no_err = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_byte_stb = 1'b0, rx_eom = 1'b0, ack_slot_stb = 1'b0, ack_slot_ok = 1'b0;
    logic rise_err_stb = 1'b0, short_err_stb = 1'b0, long_err_stb = 1'b0;
    logic [6:0] stat_clr = '0;
    logic ack_drive, nack_bcast, err_bit_req, rx_abort;
    logic [6:0] stat_flags;

    always #10 clk = ~clk;

    rx_accept_policy dut_i (.*);

    typedef struct {
        logic       ack, nack, err, abrt;
        logic [6:0] st;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic [6:0] est = '0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic cyc(input logic bs, input logic [7:0] b, input logic eo,
                       input logic as, input logic ao,
                       input logic r, input logic s, input logic l,
                       input logic [6:0] clr,
                       input logic e_ack, input logic e_nack, input logic e_err,
                       input logic e_ab, input logic [6:0] e_set, input string tag);
        exp_t e;
        @(negedge clk);
        rx_byte_stb = bs; rx_byte = b; rx_eom = eo;
        ack_slot_stb = as; ack_slot_ok = ao;
        rise_err_stb = r; short_err_stb = s; long_err_stb = l;
        stat_clr = clr;
        est = (est & ~clr) | e_set;
        e.ack = e_ack; e.nack = e_nack; e.err = e_err; e.abrt = e_ab;
        e.st = est; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic byte_c(input logic [7:0] b, input logic eo, input logic e_ack,
                          input logic e_nack, input logic e_ab, input logic [6:0] e_set,
                          input string tag);
        cyc(1, b, eo, 0, 0, 0, 0, 0, '0, e_ack, e_nack, 0, e_ab, e_set, tag);
    endtask

    task automatic slot_c(input logic ok, input logic e_ab, input logic [6:0] e_set,
                          input string tag);
        cyc(0, '0, 0, 1, ok, 0, 0, 0, '0, 0, 0, 0, e_ab, e_set, tag);
    endtask

    task automatic fault_c(input logic r, input logic s, input logic l, input logic e_err,
                           input logic e_ab, input logic [6:0] e_set, input string tag);
        cyc(0, '0, 0, 0, 0, r, s, l, '0, 0, 0, e_err, e_ab, e_set, tag);
    endtask

    task automatic clr_c(input logic [6:0] m, input string tag);
        cyc(0, '0, 0, 0, 0, 0, 0, 0, m, 0, 0, 0, 0, '0, tag);
    endtask

    // monitor: compare one expected item per cycle after the registering edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if ({ack_drive, nack_bcast, err_bit_req, rx_abort, stat_flags} !==
                    {e.ack, e.nack, e.err, e.abrt, e.st}) begin
                    errors++;
                    $display("FAIL %s: got ack=%b nack=%b err=%b abort=%b flags=%h, expected ack=%b nack=%b err=%b abort=%b flags=%h",
                             e.tag, ack_drive, nack_bcast, err_bit_req, rx_abort, stat_flags,
                             e.ack, e.nack, e.err, e.abrt, e.st);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({ack_drive, nack_bcast, err_bit_req, rx_abort, stat_flags} !== '0) begin
            errors++;
            $display("FAIL R12 reset: got %h, expected 0",
                     {ack_drive, nack_bcast, err_bit_req, rx_abort, stat_flags});
        end

        // R1 matched header and data, R10 end flag
        byte_c(8'h45, 0, 1, 0, 0, FB, "R1 header to 5 acked");
        clr_c(FB, "R11 clear byte flag");
        byte_c(8'h12, 1, 1, 0, 0, FB | FE, "R10 final byte acked with end flag");
        slot_c(1, 0, '0, "R10 final slot returns to header wait");
        clr_c(FB | FE, "R11 clear byte and end");

        // R2 non-matching, listen off
        byte_c(8'h13, 0, 0, 0, 0, '0, "R2 header to 3 ignored");
        pol_rise_stop = 1'b1; pol_rise_gen = 1'b1;
        fault_c(1, 0, 0, 0, 0, '0, "R2 fault ignored while skipping");
        byte_c(8'h99, 1, 0, 0, 0, '0, "R2 final byte ignored");
        pol_rise_stop = 1'b0; pol_rise_gen = 1'b0;

        // R1 address 0, R5 overrun
        byte_c(8'h30, 0, 1, 0, 0, FB, "R1 header to 0 acked");
        byte_c(8'h12, 0, 0, 0, 1, FO, "R5 overrun aborts without ack");
        clr_c(FALL, "R11 clear all");

        // R3 monitor, R9 missing ack at final slot
        listen_en = 1'b1;
        byte_c(8'h17, 0, 0, 0, 0, FB, "R3 monitored header not acked");
        clr_c(FB, "R11 clear byte");
        byte_c(8'h55, 1, 0, 0, 0, FB | FE, "R3 monitored final byte");
        slot_c(0, 1, FM, "R9 missing ack in monitor aborts");
        clr_c(FALL, "R11 clear all");

        // R4 broadcast, R5 broadcast overrun
        listen_en = 1'b0;
        byte_c(8'h4F, 0, 0, 0, 0, FB, "R4 broadcast received not acked");
        byte_c(8'h21, 0, 0, 1, 1, FO, "R5 broadcast overrun nack");
        clr_c(FALL, "R11 clear all");

        // R6 short, R8 rise without stop, R7 long non-broadcast
        byte_c(8'h05, 0, 1, 0, 0, FB, "R1 header to 5");
        fault_c(1, 0, 0, 0, 0, FR, "R8 rise no stop no gen");
        fault_c(0, 1, 0, 1, 0, FS, "R6 short error bit no abort");
        clr_c(FALL, "R11 clear all");
        byte_c(8'h66, 0, 1, 0, 0, FB, "R6 still accepting after faults");
        fault_c(0, 0, 1, 0, 1, FL, "R7 long aborts without error bit");
        clr_c(FALL, "R11 clear all");

        // R8 broadcast overrides
        byte_c(8'h0F, 0, 0, 0, 0, FB, "R4 broadcast header");
        clr_c(FB, "R11 clear byte");
        pol_rise_stop = 1'b1;
        fault_c(1, 0, 0, 1, 1, FR, "R8 broadcast rise with stop gives error bit");
        clr_c(FALL, "R11 clear all");
        byte_c(8'h0F, 0, 0, 0, 0, FB, "R4 broadcast header");
        pol_bc_no_err = 1'b1;
        fault_c(1, 0, 0, 0, 1, FR, "R8 broadcast no-error option suppresses bit");
        clr_c(FALL, "R11 clear all");
        pol_rise_stop = 1'b0; pol_bc_no_err = 1'b0;

        // R7 long in broadcast and with enable
        byte_c(8'h0F, 0, 0, 0, 0, FB, "R4 broadcast header");
        fault_c(0, 0, 1, 1, 1, FL, "R7 broadcast long gives error bit");
        clr_c(FALL, "R11 clear all");
        pol_long_gen = 1'b1;
        byte_c(8'h05, 0, 1, 0, 0, FB, "R1 header to 5");
        fault_c(0, 0, 1, 1, 1, FL, "R7 long with enable gives error bit");
        clr_c(FALL, "R11 clear all");
        pol_long_gen = 1'b0;

        // R9 slot ignored in accepted message
        byte_c(8'h05, 0, 1, 0, 0, FB, "R1 header to 5");
        clr_c(FB, "R11 clear byte");
        slot_c(0, 0, '0, "R9 nack slot ignored when accepted");
        byte_c(8'h77, 1, 1, 0, 0, FB | FE, "R9 still accepting after slot");
        slot_c(0, 0, '0, "R9 final slot of accepted message");
        clr_c(FALL, "R11 clear all");

        // R11 set wins over clear; single-byte message
        byte_c(8'h45, 1, 1, 0, 0, FB | FE, "R10 single byte message");
        cyc(0, '0, 0, 0, 0, 1, 0, 0, FR, 0, 0, 0, 0, FR, "R11 set beats clear");
        slot_c(1, 0, '0, "R10 slot closes message");
        clr_c(FALL, "R11 clear all");
        cyc(0, '0, 0, 0, 0, 0, 0, 0, '0, 0, 0, 0, 0, '0, "R12 quiet");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule